// File: doc/BRIEF.md
# Amplifier Reset Phase Sequencer

This block drives the reset switches of a charge-sensing amplifier that is cleared through a switched capacitor rather than by a direct short. When a reset is requested, it runs a programmed number of reset cycles. In each cycle three switch enables (A, then B, then C) are asserted one after another. Each cycle moves the amplifier output about nine tenths of the remaining distance toward its programmed reset level. Four cycles bring the output within a thousandth of that level, and four is the count used when software leaves the count register at zero. The count can be raised to stretch the reset for test.

The digital pulse processor raises the request once it has measured a pulse height. The sequencer then reports busy until the last cycle completes, and gives a single-clock done pulse at that point. No two switch enables are ever high together. Every phase is followed by one idle clock, so the switches cannot overlap even with unequal driver delays. Each phase lasts `PHASE_CLKS` clocks, so one cycle takes `3*(PHASE_CLKS+1)` clocks. With a 60 MHz clock and the default of one clock per phase, a cycle takes 100 ns.

Top module: `amp_reset_seq`

## Requirements
- R1: After reset the outputs `sw_a`, `sw_b`, `sw_c`, `busy` and `done` are all low.
- R2: A high `start_req` sampled at a rising edge while idle sets `busy` after that edge, and `sw_a` is high in that same first busy clock.
- R3: Within each cycle the enables come in the order `sw_a`, `sw_b`, `sw_c`, each high for `PHASE_CLKS` consecutive clocks.
- R4: Each phase is followed by exactly one clock with all three enables low, and at most one enable is high in any clock.
- R5: `busy` stays high for exactly N*3*(PHASE_CLKS+1) clocks, where N is the value of `cycle_cnt` sampled with the accepted request. Later changes to `cycle_cnt` have no effect on a running sequence.
- R6: A `cycle_cnt` of zero runs `DEF_CYCLES` cycles (4 by default).
- R7: `start_req` is ignored while `busy` is high: it neither restarts nor lengthens the sequence.
- R8: `done` is high for exactly one clock, in the clock right after the last busy clock. `busy` is low in that clock.
- R9: A request sampled while `done` is high is accepted, so a new sequence starts with no extra idle clock.
- R10: While `busy` is low, all three switch enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Reset request, sampled on rising edges |
| cycle_cnt | input | CNT_W | Number of reset cycles; zero selects DEF_CYCLES |
| sw_a | output | 1 | First-phase switch enable |
| sw_b | output | 1 | Second-phase switch enable |
| sw_c | output | 1 | Third-phase switch enable |
| busy | output | 1 | High while a reset sequence runs |
| done | output | 1 | One-clock pulse at the end of the final cycle |

## Verification
The bench holds `start_req` high and changes `cycle_cnt` at random throughout running sequences. A design that re-armed or re-read the count would show a longer or restarted pattern. A zero count is checked against the four-cycle default: a design that took zero literally would end at once or wrap to the maximum count. A request raised in the `done` clock must start the next sequence immediately; a design that held one extra idle clock would be one clock late on every following slot. The largest count is also run, to catch an off-by-one in the remaining-cycle counter, which would show as one cycle too many or too few.

// File: rtl/amp_reset_seq.sv
module amp_reset_seq #(
  parameter int CNT_W      = 4,
  parameter int PHASE_CLKS = 1,
  parameter int DEF_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [CNT_W-1:0] cycle_cnt,
  output logic             sw_a,
  output logic             sw_b,
  output logic             sw_c,
  output logic             busy,
  output logic             done
);
  localparam int GRP   = PHASE_CLKS + 1;
  localparam int SLOTS = 3 * GRP;
  localparam int SW    = $clog2(SLOTS);

  logic [SW-1:0]    slot;
  logic [CNT_W-1:0] left;

  wire last_slot = (slot == SW'(SLOTS - 1));
  wire [CNT_W-1:0] eff_cnt = (cycle_cnt == '0) ? CNT_W'(DEF_CYCLES) : cycle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      slot <= '0;
      left <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        busy <= start_req;
        slot <= '0;
        left <= eff_cnt - 1'b1;
      end else if (last_slot) begin
        slot <= '0;
        if (left == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          left <= left - 1'b1;
        end
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  wire in_phase = (int'(slot) % GRP) < PHASE_CLKS;
  assign sw_a = busy && in_phase && (int'(slot) / GRP == 0);
  assign sw_b = busy && in_phase && (int'(slot) / GRP == 1);
  assign sw_c = busy && in_phase && (int'(slot) / GRP == 2);

  wire [2:0] sw_v = {sw_c, sw_b, sw_a};

  assert_one_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_v));

  assert_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_v != 3'b000 && sw_v != $past(sw_v)) |-> $past(sw_v) == 3'b000);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sw_v == 3'b000);

  assert_start_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sw_a);

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_slot) |=> busy && slot == $past(slot) + 1'b1);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
endmodule

// File: tb/amp_reset_seq_tb.sv
`timescale 1ns/1ps
module amp_reset_seq_tb_top;
  localparam int CNT_W = 4;
  localparam int PH    = 1;
  localparam int DEFN  = 4;
  localparam int SLOTS = 3 * (PH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic [CNT_W-1:0] cycle_cnt = '0;
  logic sw_a, sw_b, sw_c, busy, done;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  amp_reset_seq #(.CNT_W(CNT_W), .PHASE_CLKS(PH), .DEF_CYCLES(DEFN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cycle_cnt(cycle_cnt),
    .sw_a(sw_a), .sw_b(sw_b), .sw_c(sw_c), .busy(busy), .done(done));

  function automatic logic [4:0] exp_busy_word(input int k);
    int s = k % SLOTS;
    logic [2:0] p = ((s % (PH + 1)) < PH) ? 3'(1 << (s / (PH + 1))) : 3'b000;
    return {1'b0, 1'b1, p};
  endfunction

  task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {done,busy,c,b,a} act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] obs();
    return {done, busy, sw_c, sw_b, sw_a};
  endfunction

  task automatic run_seq(input int cnt, input bit rnd, input bit chain,
                         input int next_cnt, input string run_tag);
    int n = (cnt == 0) ? DEFN : cnt;
    @(negedge clk);
    for (int k = 0; k < n * SLOTS; k++) begin
      string t;
      int s = k % SLOTS;
      if (k == 0) t = "R2";
      else if ((s % (PH + 1)) < PH) t = "R3";
      else t = "R4";
      chk(obs(), exp_busy_word(k), {t, " in ", run_tag});
      if (rnd) begin
        start_req = 1'($urandom);
        cycle_cnt = CNT_W'($urandom);
      end else begin
        start_req = 1'b0;
      end
      @(negedge clk);
    end
    chk(obs(), 5'b10000, {"R5 R8 end of ", run_tag});
    if (chain) begin
      start_req = 1'b1;
      cycle_cnt = CNT_W'(next_cnt);
    end else begin
      start_req = 1'b0;
      @(negedge clk);
      chk(obs(), 5'b00000, {"R8 after ", run_tag});
    end
  endtask

  task automatic kick(input int cnt);
    @(negedge clk);
    cycle_cnt = CNT_W'(cnt);
    start_req = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(obs(), 5'b00000, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(obs(), 5'b00000, "R1 after reset");

    repeat (4) begin
      @(negedge clk);
      chk(obs(), 5'b00000, "R10 idle");
    end

    kick(4);
    run_seq(4, 1'b0, 1'b0, 0, "R5 count4");
    kick(0);
    run_seq(0, 1'b0, 1'b0, 0, "R6 zero");
    kick(1);
    run_seq(1, 1'b0, 1'b0, 0, "R5 count1");
    kick(15);
    run_seq(15, 1'b0, 1'b0, 0, "R5 max");

    kick(2);
    run_seq(2, 1'b0, 1'b1, 3, "R9 first");
    run_seq(3, 1'b1, 1'b0, 0, "R9 chained");

    for (int r = 0; r < 8; r++) begin
      int c = int'($urandom_range(0, 15));
      kick(c);
      run_seq(c, 1'b1, 1'b0, 0, "R7 random");
    end

    repeat (3) begin
      @(negedge clk);
      chk(obs(), 5'b00000, "R10 final idle");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule